// File: doc/BRIEF.md
# Transceiver Mode and Wake-Up Controller

This block holds the digital mode logic of a high-speed CAN physical-layer transceiver. It chooses between an active mode, where the transmitter and the main receiver run, and a low-power standby mode. In standby only a low-power bus comparator is watched. The choice comes from a standby select pin and from a supply undervoltage flag. While the flag is raised, the block stays in standby whatever the select pin says.

The receive-data output has two jobs. In active mode it mirrors the main comparator: low while the bus is dominant, high while it is recessive. In standby it carries a wake request. The bus must first stay dominant for longer than a qualification time. After a further flag delay the output goes low. It rises again a release delay after the bus goes recessive, and every wake pulse is held low for a minimum width. A stuck-dominant guard drives the output high if the bus stays dominant for longer than a timeout.

Leaving standby passes through a settling interval. During that interval the output is held high and the transmitter stays off. Both comparator inputs go through two-flop synchronisers. Every time value is a parameter counted in clock cycles.

Top module: `xcvrModeWake`

## Requirements
- R1: A synchronous active-low reset puts the block in standby, with `rxdOut` high and `txEnable` and `rxEnable` low.
- R2: With `standbySel` low and `supplyLow` low, the block spends SETTLE_CYC cycles settling before it enters active mode. `txEnable` rises exactly SETTLE_CYC+1 cycles after the request. During settling `rxdOut` stays high and `txEnable` stays low.
- R3: In active mode, `rxdOut` is the inverse of `busDomNorm` (1 = dominant) and follows it with a two-cycle latency. `busDomLp` has no effect on `rxdOut`.
- R4: `standbySel` high moves the block to standby on the next cycle. `txEnable` and `rxEnable` drop, and `busDomNorm` no longer affects `rxdOut`.
- R5: In standby, a wake needs more than WAKE_MIN_CYC consecutive dominant samples of `busDomLp`. A dominant pulse of exactly WAKE_MIN_CYC cycles never drives `rxdOut` low.
- R6: A qualified wake drives `rxdOut` low exactly WAKE_MIN_CYC+FLAG_DLY_CYC+4 cycles after `busDomLp` goes dominant. The output then stays low even if the bus is released during the flag delay.
- R7: If the minimum width has already been met, `rxdOut` returns high RELEASE_DLY_CYC+3 cycles after `busDomLp` returns recessive.
- R8: A wake pulse on `rxdOut` lasts at least MIN_LOW_CYC cycles. If the bus is released as soon as the pulse starts, it lasts exactly MIN_LOW_CYC cycles.
- R9: In standby, if `busDomLp` stays dominant, `rxdOut` goes high BUS_TMO_CYC+3 cycles after the dominant edge and stays high while the bus remains dominant. After a recessive phase, a new dominant phase starts a fresh wake.
- R10: While `supplyLow` is high the block is in standby (from the next cycle) and `standbySel` is ignored. When `supplyLow` clears with `standbySel` low, the R2 settling sequence follows.
- R11: Leaving standby clears the wake qualification and timeout counts. After a return to standby with the bus still dominant, the wake drives `rxdOut` low WAKE_MIN_CYC+FLAG_DLY_CYC+3 cycles after `standbySel` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| standbySel | input | 1 | 1 requests standby, 0 requests active mode |
| supplyLow | input | 1 | Supply undervoltage flag; forces standby |
| busDomNorm | input | 1 | Main receiver comparator, 1 = dominant (asynchronous) |
| busDomLp | input | 1 | Low-power receiver comparator, 1 = dominant (asynchronous) |
| rxdOut | output | 1 | Receive data / wake request, low = dominant or wake |
| txEnable | output | 1 | Transmitter enable |
| rxEnable | output | 1 | Main receiver enable |

## Verification
Every result has a fixed due cycle counted from the negative edge where the stimulus is driven. A comparator change reaches `rxdOut` in active mode after two edges. A wake is due after WAKE_MIN_CYC+FLAG_DLY_CYC+4 edges, a release after RELEASE_DLY_CYC+3, a timeout after BUS_TMO_CYC+3, and active mode after SETTLE_CYC+1. The bench waits an exact number of rising edges and then samples on the next falling edge. Each latency is checked twice: one cycle before it is due, where the old value must still be present, and on the cycle it is due. Pulse widths are counted sample by sample.

// File: rtl/xcvrPkg.sv
package xcvrPkg;

  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_SETTLE  = 2'd1,
    MODE_NORMAL  = 2'd2
  } xcvrMode_e;

  typedef enum logic [2:0] {
    WK_IDLE    = 3'd0,
    WK_PEND    = 3'd1,
    WK_ACTIVE  = 3'd2,
    WK_RELEASE = 3'd3,
    WK_TIMEOUT = 3'd4
  } wakeState_e;

  // strobes from the mode control to the wake datapath
  typedef struct packed {
    logic runWake;   // standby: wake path evaluates the bus
    logic clrWake;   // standby is being left on this edge
  } wakeCtrl_t;

endpackage

// File: rtl/xcvrSync.sv
module xcvrSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/xcvrModeCtl.sv
module xcvrModeCtl
  import xcvrPkg::*;
#(
  parameter int SETTLE_CYC = 2350
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      standbySel,
  input  logic      supplyLow,
  output xcvrMode_e modeState,
  output wakeCtrl_t wakeCtrl
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

  logic          goStandby;
  logic [SW-1:0] settleCnt;

  // undervoltage overrides the select pin
  assign goStandby = standbySel | supplyLow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeState <= MODE_STANDBY;
      settleCnt <= '0;
    end else begin
      unique case (modeState)
        MODE_STANDBY: begin
          settleCnt <= '0;
          if (!goStandby) modeState <= MODE_SETTLE;
        end
        MODE_SETTLE: begin
          if (goStandby) begin
            modeState <= MODE_STANDBY;
            settleCnt <= '0;
          end else if (settleCnt == SETTLE_LAST) begin
            modeState <= MODE_NORMAL;
            settleCnt <= '0;
          end else begin
            settleCnt <= settleCnt + SW'(1);
          end
        end
        MODE_NORMAL: begin
          if (goStandby) modeState <= MODE_STANDBY;
        end
        default: modeState <= MODE_STANDBY;
      endcase
    end
  end

  always_comb begin
    wakeCtrl.runWake = (modeState == MODE_STANDBY);
    wakeCtrl.clrWake = (modeState == MODE_STANDBY) && !goStandby;
  end

  // R4 / R10: a standby request or undervoltage is honoured on the next edge
  assert_standby_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    goStandby |=> modeState == MODE_STANDBY);

  assert_undervolt_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    supplyLow |=> modeState != MODE_NORMAL);

  // R2: active mode is entered only at the end of a full settling count
  assert_settle_length_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeState == MODE_SETTLE && !goStandby && settleCnt != SETTLE_LAST)
      |=> modeState == MODE_SETTLE);

endmodule

// File: rtl/xcvrWakePath.sv
module xcvrWakePath
  import xcvrPkg::*;
#(
  parameter int WAKE_MIN_CYC    = 100,
  parameter int FLAG_DLY_CYC    = 175,
  parameter int RELEASE_DLY_CYC = 130,
  parameter int MIN_LOW_CYC     = 250,
  parameter int BUS_TMO_CYC     = 125000
) (
  input  logic      clk,
  input  logic      rstN,
  input  wakeCtrl_t wakeCtrl,
  input  logic      lpDom,
  output logic      wakeLow
);

  localparam int DW = $clog2(BUS_TMO_CYC + 1);
  localparam int PMAX = (FLAG_DLY_CYC > RELEASE_DLY_CYC) ? FLAG_DLY_CYC : RELEASE_DLY_CYC;
  localparam int PW = $clog2(PMAX + 1);
  localparam int MW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [DW-1:0] TMO_VAL  = DW'(BUS_TMO_CYC);
  localparam logic [DW-1:0] WAKE_VAL = DW'(WAKE_MIN_CYC);
  localparam logic [PW-1:0] FLAG_END = PW'(FLAG_DLY_CYC - 1);
  localparam logic [PW-1:0] REL_END  = PW'(RELEASE_DLY_CYC - 1);
  localparam logic [MW-1:0] LOW_END  = MW'(MIN_LOW_CYC - 1);
  localparam logic [MW-1:0] LOW_SAT  = MW'(MIN_LOW_CYC);

  wakeState_e    wState, wNext;
  logic [DW-1:0] domRun;
  logic [PW-1:0] phaseCnt, phaseNext;
  logic [MW-1:0] lowCnt, lowNext;
  logic          tmoHit, qualified, holdClear;

  assign holdClear = !wakeCtrl.runWake || wakeCtrl.clrWake;
  assign tmoHit    = (domRun == TMO_VAL);
  assign qualified = (domRun > WAKE_VAL);
  assign wakeLow   = (wState == WK_ACTIVE) || (wState == WK_RELEASE);

  // dominant run length, shared by wake qualification and stuck-bus timeout
  always_ff @(posedge clk) begin
    if (!rstN || holdClear)  domRun <= '0;
    else if (!lpDom)         domRun <= '0;
    else if (!tmoHit)        domRun <= domRun + DW'(1);
  end

  always_comb begin
    wNext     = wState;
    phaseNext = phaseCnt;
    lowNext   = lowCnt;
    unique case (wState)
      WK_IDLE: begin
        if (qualified) begin
          wNext     = WK_PEND;
          phaseNext = '0;
        end
      end
      WK_PEND: begin
        if (tmoHit) begin
          wNext = WK_TIMEOUT;
        end else if (phaseCnt == FLAG_END) begin
          wNext   = WK_ACTIVE;
          lowNext = '0;
        end else begin
          phaseNext = phaseCnt + PW'(1);
        end
      end
      WK_ACTIVE: begin
        if (lowCnt != LOW_SAT) lowNext = lowCnt + MW'(1);
        if (tmoHit) begin
          wNext = WK_TIMEOUT;
        end else if (!lpDom) begin
          wNext     = WK_RELEASE;
          phaseNext = '0;
        end
      end
      WK_RELEASE: begin
        if (lowCnt != LOW_SAT) lowNext = lowCnt + MW'(1);
        if (lpDom) begin
          wNext = WK_ACTIVE;
        end else if (phaseCnt >= REL_END && lowCnt >= LOW_END) begin
          wNext = WK_IDLE;
        end else if (phaseCnt < REL_END) begin
          phaseNext = phaseCnt + PW'(1);
        end
      end
      WK_TIMEOUT: begin
        if (!lpDom) wNext = WK_IDLE;
      end
      default: wNext = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || holdClear) begin
      wState   <= WK_IDLE;
      phaseCnt <= '0;
      lowCnt   <= '0;
    end else begin
      wState   <= wNext;
      phaseCnt <= phaseNext;
      lowCnt   <= lowNext;
    end
  end

  // R9: a run that reaches the timeout while still dominant releases the flag
  assert_tmo_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    (wakeCtrl.runWake && tmoHit && lpDom) |=> !wakeLow);

  // R5: no pending wake without a qualified dominant run
  assert_no_early_wake_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wState == WK_IDLE && !qualified) |=> wState != WK_PEND);

  // R8: a release-driven end of the pulse respects the minimum width
  assert_min_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(wakeLow) && $past(wState) == WK_RELEASE && $past(!holdClear))
      |-> $past(lowCnt) >= LOW_END);

  // R11: outside standby the wake path holds nothing
  assert_cleared_off_standby_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wakeCtrl.runWake |=> (domRun == '0 && !wakeLow));

endmodule

// File: rtl/xcvrModeWake.sv
module xcvrModeWake
  import xcvrPkg::*;
#(
  parameter int SETTLE_CYC      = 2350,
  parameter int WAKE_MIN_CYC    = 100,
  parameter int FLAG_DLY_CYC    = 175,
  parameter int RELEASE_DLY_CYC = 130,
  parameter int MIN_LOW_CYC     = 250,
  parameter int BUS_TMO_CYC     = 125000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic standbySel,
  input  logic supplyLow,
  input  logic busDomNorm,
  input  logic busDomLp,
  output logic rxdOut,
  output logic txEnable,
  output logic rxEnable
);

  xcvrMode_e  modeState;
  wakeCtrl_t  wakeCtrl;
  logic [1:0] cmpSync;
  logic       normDom, lpDom, wakeLow;

  xcvrSync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_cmpSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({busDomLp, busDomNorm}),
    .syncOut (cmpSync)
  );

  assign normDom = cmpSync[0];
  assign lpDom   = cmpSync[1];

  xcvrModeCtl #(.SETTLE_CYC(SETTLE_CYC)) i_modeCtl (
    .clk        (clk),
    .rstN       (rstN),
    .standbySel (standbySel),
    .supplyLow  (supplyLow),
    .modeState  (modeState),
    .wakeCtrl   (wakeCtrl)
  );

  xcvrWakePath #(
    .WAKE_MIN_CYC    (WAKE_MIN_CYC),
    .FLAG_DLY_CYC    (FLAG_DLY_CYC),
    .RELEASE_DLY_CYC (RELEASE_DLY_CYC),
    .MIN_LOW_CYC     (MIN_LOW_CYC),
    .BUS_TMO_CYC     (BUS_TMO_CYC)
  ) i_wakePath (
    .clk      (clk),
    .rstN     (rstN),
    .wakeCtrl (wakeCtrl),
    .lpDom    (lpDom),
    .wakeLow  (wakeLow)
  );

  always_comb begin
    unique case (modeState)
      MODE_NORMAL:  rxdOut = !normDom;
      MODE_STANDBY: rxdOut = !wakeLow;
      default:      rxdOut = 1'b1;
    endcase
  end

  assign txEnable = (modeState == MODE_NORMAL);
  assign rxEnable = (modeState != MODE_STANDBY);

  // R2: the transmitter only comes up after the select pin asked for it
  assert_tx_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnable) |-> $past(!standbySel && !supplyLow));

endmodule

// File: tb/test_xcvrModeWake.sv
module test_xcvrModeWake;

  localparam int W = 4;
  localparam int F = 6;
  localparam int R = 3;
  localparam int M = 20;
  localparam int S = 5;
  localparam int T = 60;

  logic clk, rstN, standbySel, supplyLow, busDomNorm, busDomLp;
  logic rxdOut, txEnable, rxEnable;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   finished = 0;

  xcvrModeWake #(
    .SETTLE_CYC(S), .WAKE_MIN_CYC(W), .FLAG_DLY_CYC(F),
    .RELEASE_DLY_CYC(R), .MIN_LOW_CYC(M), .BUS_TMO_CYC(T)
  ) i_xcvrModeWake (
    .clk(clk), .rstN(rstN), .standbySel(standbySel), .supplyLow(supplyLow),
    .busDomNorm(busDomNorm), .busDomLp(busDomLp),
    .rxdOut(rxdOut), .txEnable(txEnable), .rxEnable(rxEnable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 rxd after reset", rxdOut, 1);
    chk("R1 tx after reset", txEnable, 0);
    chk("R1 rx after reset", rxEnable, 0);
  endtask

  task automatic tWakeQualify();
    int lows = 0;
    int width = 1;
    busDomLp = 1'b1;
    waitEdges(W);
    busDomLp = 1'b0;
    for (int i = 0; i < 40; i++) begin
      waitEdges(1);
      if (rxdOut == 1'b0) lows++;
    end
    chk("R5 short pulse gives no wake", lows, 0);
    busDomLp = 1'b1;
    waitEdges(W + 1);
    busDomLp = 1'b0;
    waitEdges(F + 2);
    chk("R6 rxd still high one cycle early", rxdOut, 1);
    waitEdges(1);
    chk("R6 rxd low at wake latency", rxdOut, 0);
    while (rxdOut == 1'b0 && width < 200) begin
      waitEdges(1);
      if (rxdOut == 1'b0) width++;
    end
    chk("R8 minimum low width", width, M);
    waitEdges(5);
  endtask

  task automatic tRelease();
    busDomLp = 1'b1;
    waitEdges(W + F + 4);
    chk("R6 long dominant wakes", rxdOut, 0);
    waitEdges(30);
    busDomLp = 1'b0;
    waitEdges(R + 2);
    chk("R7 rxd low before release delay", rxdOut, 0);
    waitEdges(1);
    chk("R7 rxd high after release delay", rxdOut, 1);
    waitEdges(5);
  endtask

  task automatic tTimeout();
    busDomLp = 1'b1;
    waitEdges(W + F + 4);
    chk("R9 wake before timeout", rxdOut, 0);
    waitEdges(T + 2 - (W + F + 4));
    chk("R9 still low one cycle before timeout", rxdOut, 0);
    waitEdges(1);
    chk("R9 released by timeout", rxdOut, 1);
    waitEdges(20);
    chk("R9 stays high on clamped bus", rxdOut, 1);
    busDomLp = 1'b0;
    waitEdges(5);
    chk("R9 high after bus recessive", rxdOut, 1);
    busDomLp = 1'b1;
    waitEdges(W + F + 4);
    chk("R9 fresh wake after timeout", rxdOut, 0);
    busDomLp = 1'b0;
    waitEdges(M + 5);
    chk("R9 second wake released", rxdOut, 1);
  endtask

  task automatic tNormal();
    busDomNorm = 1'b1;
    standbySel = 1'b0;
    waitEdges(S);
    chk("R2 tx off while settling", txEnable, 0);
    chk("R2 rxd high while settling", rxdOut, 1);
    waitEdges(1);
    chk("R2 tx on after settling", txEnable, 1);
    chk("R2 rx on in active mode", rxEnable, 1);
    chk("R3 rxd low on dominant", rxdOut, 0);
    busDomNorm = 1'b0;
    waitEdges(1);
    chk("R3 rxd old value after one cycle", rxdOut, 0);
    waitEdges(1);
    chk("R3 rxd high on recessive", rxdOut, 1);
    busDomNorm = 1'b1;
    waitEdges(2);
    chk("R3 rxd follows dominant again", rxdOut, 0);
    busDomNorm = 1'b0;
    busDomLp = 1'b1;
    waitEdges(W + F + 6);
    chk("R3 low-power comparator ignored", rxdOut, 1);
    busDomLp = 1'b0;
    waitEdges(3);
    busDomNorm = 1'b1;
    standbySel = 1'b1;
    waitEdges(1);
    chk("R4 tx off in standby", txEnable, 0);
    chk("R4 rx off in standby", rxEnable, 0);
    chk("R4 rxd high in standby", rxdOut, 1);
    waitEdges(5);
    chk("R4 main comparator ignored", rxdOut, 1);
    busDomNorm = 1'b0;
  endtask

  task automatic tUndervolt();
    standbySel = 1'b0;
    supplyLow = 1'b1;
    waitEdges(S + 10);
    chk("R10 select ignored under undervoltage", txEnable, 0);
    chk("R10 rx off under undervoltage", rxEnable, 0);
    busDomLp = 1'b1;
    waitEdges(W + F + 4);
    chk("R10 standby wake under undervoltage", rxdOut, 0);
    busDomLp = 1'b0;
    waitEdges(M + 5);
    supplyLow = 1'b0;
    waitEdges(S);
    chk("R10 still settling after recovery", txEnable, 0);
    waitEdges(1);
    chk("R10 active after recovery", txEnable, 1);
    supplyLow = 1'b1;
    waitEdges(1);
    chk("R10 undervoltage forces standby", txEnable, 0);
    supplyLow = 1'b0;
    standbySel = 1'b1;
    waitEdges(3);
  endtask

  task automatic tClear();
    busDomLp = 1'b1;
    waitEdges(W);
    standbySel = 1'b0;
    waitEdges(1);
    chk("R11 rxd high during settling", rxdOut, 1);
    standbySel = 1'b1;
    waitEdges(W + F + 2);
    chk("R11 count restarted after standby exit", rxdOut, 1);
    waitEdges(1);
    chk("R11 wake after full requalification", rxdOut, 0);
    busDomLp = 1'b0;
    waitEdges(M + 5);
    chk("R11 released", rxdOut, 1);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0;
    standbySel = 1'b1;
    supplyLow = 1'b0;
    busDomNorm = 1'b0;
    busDomLp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    tReset();
    waitEdges(2);
    tWakeQualify();
    tRelease();
    tTimeout();
    tNormal();
    waitEdges(3);
    tUndervolt();
    tClear();
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

endmodule